// File: doc/BRIEF.md
# Dual-Source Microprogram Sequencer

This block is a compositional microprogrammed control unit for a fixed control algorithm of seventeen microinstructions. The microinstructions are held in an internal constant control store. A start pulse puts the unit into its fetch state at address 00000. On every following cycle it reads one word and drives that word's microoperations. Runs of consecutive words form linear chains, and the unit moves along a chain by incrementing its 5-bit address counter. At the last word of a chain, a small transition block looks at the four logic conditions and loads a new address.

The chain that has just ended is identified from two sources. The two chain exits used most often carry a one-hot tag in two spare bits of the control word. Every other exit is recognised from the upper three address bits. Because of this, the next-address terms for the busiest exits depend only on one tag bit and the conditions. A word marked as final stops fetching and raises a done indication. A later start pulse runs the algorithm again.

Top module: `mcu_dual_src`

## Requirements
- R1: After reset, busy=0, done=0, addr=00000 and y=0000.
- R2: A start pulse while idle leads, one cycle later, to busy=1, done=0 and addr=00000.
- R3: While busy, y shows the microoperations of the word at addr; while idle, y=0000. The values are y[3:0] per address: 00000:1100, 00001:0011, 00010:0110, 00011:1001, 00100:0010, 00101:1010, 00110:0111, 00111:1100, 01000:1010, 01011:0011, 01100:1010, 01110:0010, 01111:0011, 10000:1100, 10010:1000, 10011:0100, 10100:0001.
- R4: While busy at any address other than 00001, 00110, 01000, 01100, 10000 and 10100, the next address is addr+1.
- R5: At 00001 the next address is 00010 when x[0]=1. It is 00111 when x[0]=0 and x[1]=1. It is 01011 when both are 0.
- R6: At 00110 the next address is 01110 when x[3]=1, otherwise 10010.
- R7: At 01000 and at 01100 the next address is 00101 when x[2]=1, otherwise 00000.
- R8: At 10000 and at 10100 the unit finishes. In the next cycle busy=0 and done=1, addr keeps its value and y=0000.
- R9: A start pulse while busy has no effect on the address sequence.
- R10: A start pulse after the unit has finished clears done and restarts the unit at 00000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start pulse |
| x | input | 4 | Logic conditions; x[0] is the first condition |
| y | output | 4 | Microoperations of the current word |
| busy | output | 1 | Fetch state |
| done | output | 1 | Set when a final word has executed |
| addr | output | 5 | Address counter |

## Verification
The hardest behaviour to reach from the ports is a start pulse that arrives on the same cycle as a chain exit, and in particular the exit that leads to the second final word at 10100. That word is reached only through the 00110 exit with x[3]=0. The bench drives random conditions and random start pulses on every cycle of many runs. It also forces each branch polarity in directed runs, including a start pulse held high through a whole run, so that every exit sees stray starts.

// File: rtl/mcu_dual_src_pkg.sv
package mcu_dual_src_pkg;
    localparam int ADDR_W = 5;
    localparam int OP_W   = 4;
    localparam int COND_W = 4;
    localparam int CODE_W = 3;

    typedef struct packed {
        logic            jump;
        logic [OP_W-1:0] op;
        logic            halt;
        logic            tag_b;
        logic            tag_a;
    } cword_t;
endpackage

// File: rtl/mcu_ctrl_rom.sv
module mcu_ctrl_rom
    import mcu_dual_src_pkg::*;
(
    input  logic [ADDR_W-1:0] rd_addr,
    output cword_t            word
);
    always_comb begin
        word = '0;
        case (rd_addr)
            5'b00000: word = '{jump:1'b0, op:4'b1100, halt:1'b0, tag_b:1'b0, tag_a:1'b0};
            5'b00001: word = '{jump:1'b1, op:4'b0011, halt:1'b0, tag_b:1'b0, tag_a:1'b1};
            5'b00010: word = '{jump:1'b0, op:4'b0110, halt:1'b0, tag_b:1'b0, tag_a:1'b0};
            5'b00011: word = '{jump:1'b0, op:4'b1001, halt:1'b0, tag_b:1'b0, tag_a:1'b0};
            5'b00100: word = '{jump:1'b0, op:4'b0010, halt:1'b0, tag_b:1'b0, tag_a:1'b0};
            5'b00101: word = '{jump:1'b0, op:4'b1010, halt:1'b0, tag_b:1'b0, tag_a:1'b0};
            5'b00110: word = '{jump:1'b1, op:4'b0111, halt:1'b0, tag_b:1'b1, tag_a:1'b0};
            5'b00111: word = '{jump:1'b0, op:4'b1100, halt:1'b0, tag_b:1'b0, tag_a:1'b0};
            5'b01000: word = '{jump:1'b1, op:4'b1010, halt:1'b0, tag_b:1'b0, tag_a:1'b0};
            5'b01011: word = '{jump:1'b0, op:4'b0011, halt:1'b0, tag_b:1'b0, tag_a:1'b0};
            5'b01100: word = '{jump:1'b1, op:4'b1010, halt:1'b0, tag_b:1'b0, tag_a:1'b0};
            5'b01110: word = '{jump:1'b0, op:4'b0010, halt:1'b0, tag_b:1'b0, tag_a:1'b0};
            5'b01111: word = '{jump:1'b0, op:4'b0011, halt:1'b0, tag_b:1'b0, tag_a:1'b0};
            5'b10000: word = '{jump:1'b1, op:4'b1100, halt:1'b1, tag_b:1'b0, tag_a:1'b0};
            5'b10010: word = '{jump:1'b0, op:4'b1000, halt:1'b0, tag_b:1'b0, tag_a:1'b0};
            5'b10011: word = '{jump:1'b0, op:4'b0100, halt:1'b0, tag_b:1'b0, tag_a:1'b0};
            5'b10100: word = '{jump:1'b1, op:4'b0001, halt:1'b1, tag_b:1'b0, tag_a:1'b0};
            default:  word = '0;
        endcase
    end
endmodule

// File: rtl/mcu_xfer_logic.sv
module mcu_xfer_logic
    import mcu_dual_src_pkg::*;
(
    input  logic              tag_a,
    input  logic              tag_b,
    input  logic [CODE_W-1:0] chain_code,
    input  logic [COND_W-1:0] cond,
    output logic [ADDR_W-1:0] target
);
    always_comb begin
        target = '0;
        if (tag_a) begin
            if (cond[0])      target = ADDR_W'(5'b00010);
            else if (cond[1]) target = ADDR_W'(5'b00111);
            else              target = ADDR_W'(5'b01011);
        end else if (tag_b) begin
            target = cond[3] ? ADDR_W'(5'b01110) : ADDR_W'(5'b10010);
        end else if (chain_code == 3'b010 || chain_code == 3'b011) begin
            target = cond[2] ? ADDR_W'(5'b00101) : ADDR_W'(5'b00000);
        end
    end
endmodule

// File: rtl/mcu_dual_src.sv
module mcu_dual_src
    import mcu_dual_src_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [COND_W-1:0] x,
    output logic [OP_W-1:0]   y,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] addr
);
    typedef struct packed {
        logic              run;
        logic              fin;
        logic [ADDR_W-1:0] pc;
    } state_t;

    state_t            st_d, st_q;
    cword_t            word;
    logic [ADDR_W-1:0] target;

    mcu_ctrl_rom i_rom (
        .rd_addr (st_q.pc),
        .word    (word)
    );

    mcu_xfer_logic i_xfer (
        .tag_a      (word.tag_a),
        .tag_b      (word.tag_b),
        .chain_code (st_q.pc[ADDR_W-1 -: CODE_W]),
        .cond       (x),
        .target     (target)
    );

    always_comb begin
        st_d = st_q;
        if (!st_q.run) begin
            if (start) begin
                st_d.run = 1'b1;
                st_d.fin = 1'b0;
                st_d.pc  = '0;
            end
        end else if (word.halt) begin
            st_d.run = 1'b0;
            st_d.fin = 1'b1;
        end else if (word.jump) begin
            st_d.pc = target;
        end else begin
            st_d.pc = st_q.pc + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign y    = st_q.run ? word.op : '0;
    assign busy = st_q.run;
    assign done = st_q.fin;
    assign addr = st_q.pc;

    assert_start_load_R2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && !done && addr == '0));

    assert_step_R4: assert property (@(posedge clk) disable iff (rst)
        (busy && !word.jump && !word.halt) |=> (busy && addr == $past(addr) + 1'b1));

    assert_finish_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && word.halt) |=> (!busy && done && $stable(addr)));

    assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (y == '0));

    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && !word.halt && start) |=> busy);
endmodule

// File: tb/test_mcu_dual_src.sv
module test_mcu_dual_src;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [3:0] x = 4'b0;
    logic [3:0] y;
    logic       busy, done;
    logic [4:0] addr;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic       m_run, m_fin;
    logic [4:0] m_pc;

    always #10 clk = ~clk;

    mcu_dual_src i_mcu_dual_src (
        .clk(clk), .rst(rst), .start(start), .x(x),
        .y(y), .busy(busy), .done(done), .addr(addr)
    );

    function automatic logic [3:0] exp_op(input logic [4:0] a);
        case (a)
            5'd0: return 4'b1100;  5'd1: return 4'b0011;  5'd2: return 4'b0110;
            5'd3: return 4'b1001;  5'd4: return 4'b0010;  5'd5: return 4'b1010;
            5'd6: return 4'b0111;  5'd7: return 4'b1100;  5'd8: return 4'b1010;
            5'd11: return 4'b0011; 5'd12: return 4'b1010; 5'd14: return 4'b0010;
            5'd15: return 4'b0011; 5'd16: return 4'b1100; 5'd18: return 4'b1000;
            5'd19: return 4'b0100; 5'd20: return 4'b0001;
            default: return 4'b0000;
        endcase
    endfunction

    function automatic logic [4:0] exp_next(input logic [4:0] a, input logic [3:0] c);
        case (a)
            5'd1:  return c[0] ? 5'd2 : (c[1] ? 5'd7 : 5'd11); // R5
            5'd6:  return c[3] ? 5'd14 : 5'd18;                // R6
            5'd8, 5'd12: return c[2] ? 5'd5 : 5'd0;            // R7
            default: return a + 5'd1;                          // R4
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_step();
        if (!m_run) begin
            if (start) begin m_run = 1; m_fin = 0; m_pc = 0; end
        end else if (m_pc == 5'd16 || m_pc == 5'd20) begin
            m_run = 0; m_fin = 1;
        end else begin
            m_pc = exp_next(m_pc, x);
        end
    endtask

    task automatic compare(input string req);
        check({req, " busy"}, busy, m_run);
        check({req, " done"}, done, m_fin);
        check({req, " addr"}, addr, m_pc);
        check("R3 y", y, m_run ? exp_op(m_pc) : 4'b0);
    endtask

    // mode: 0 random, 1 fixed x with start held, 2 fixed x
    task automatic run(input int mode, input logic [3:0] fx, input int max_steps);
        @(negedge clk);
        start = 1'b1; x = fx;
        model_step();
        @(negedge clk);
        compare(m_fin ? "R10" : "R2");
        for (int i = 0; i < max_steps && m_run; i++) begin
            x     = (mode == 0) ? 4'($urandom_range(0, 15)) : fx;
            start = (mode == 1) ? 1'b1 : ((mode == 0) ? 1'($urandom_range(0, 1)) : 1'b0);
            model_step();
            @(negedge clk);
            compare(start ? "R9" : "R4-R8 step");
            if (!m_run) compare("R8");
        end
        start = 1'b0;
        if (m_run) begin
            rst = 1'b1; @(negedge clk); rst = 1'b0;
            m_run = 0; m_fin = 0; m_pc = 0;
            compare("R1");
        end
    endtask

    initial begin
        void'($urandom(32'd20150410));
        m_run = 0; m_fin = 0; m_pc = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        compare("R1");
        // R5/R6 directed: x1=1 at O1, x4 at O2, x3 at O3/O4
        run(2, 4'b0001, 40);   // O1->00010 ... O2 x4=0 -> 10100 halt
        run(2, 4'b1001, 40);   // O2 x4=1 -> 10000 halt
        run(2, 4'b0010, 40);   // R5 x2 path -> 00111, O3 x3=0 loops
        run(1, 4'b0100, 40);   // R5 both zero, R7 x3=1, start held (R9)
        run(1, 4'b1101, 40);
        for (int r = 0; r < 300; r++) run(0, 4'b0000, 60);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule